// File: doc/BRIEF.md
# Overcurrent Latch-Off Fault Sequencer

This block is the protection sequencer of a multiphase regulator controller. When the current limit is reported, it does not switch the phases off. It moves to a grace period in which the phases keep switching, and the outcome of that period is settled by whichever comes first. If the delay threshold is crossed, the controller latches off. If the overload goes away, the controller returns to regulation. That return goes straight back to running when the output is still inside its power-good window. It goes through a fresh soft-start when the output has sagged below that window.

The delay threshold comes from one of two sources, chosen by a parameter. The default is a digital comparator flag standing in for the analog timing capacitor. The other source is an internal cycle counter that models the discharge time. A latched-off controller stays off until power-on reset, or until the enable input is seen low on at least two consecutive clocks. A separate startup clamp select is raised whenever the phases run while the output is below the startup level.

Top module: `ocp_fault_seq`

## Requirements
- R1: While `porRstN` is low, and on the first clock after it is released with `enPin` low, `phaseEn`, `ssReq`, `latchedOff` and `secLimSel` are all 0.
- R2: From the off state, sampling `enPin` high sets `phaseEn` to 1 and pulses `ssReq` high for exactly one clock. A sampled `ssDone` then moves the block to the run state, with `phaseEn` still 1.
- R3: A sampled `limitHit` in soft-start or run enters the delay state. During the delay state `phaseEn` stays 1 and `latchedOff` stays 0.
- R4: In the delay state, a high threshold indication latches the block off: `latchedOff` becomes 1 and `phaseEn` becomes 0 one clock later. The threshold wins over a fault that clears in the same clock.
- R5: In the delay state, when `limitHit` is low, the threshold is not reached and `pgoodInWin` is 1, the block returns to run with `phaseEn` 1 and no `ssReq` pulse.
- R6: In the delay state, when `limitHit` is low, the threshold is not reached and `pgoodInWin` is 0, the block re-enters soft-start with a one-clock `ssReq` pulse.
- R7: Once latched off, the block stays latched whatever `limitHit` and `dlyTrip` do, and also when `enPin` goes low for only a single clock.
- R8: `enPin` sampled low on two consecutive clocks sends the block to the off state from any state, clearing all outputs. A later high `enPin` starts a new soft-start.
- R9: With the comparator threshold source and `dlyTrip` held at 0, the block never latches off, however long `limitHit` stays high.
- R10: `secLimSel` equals the previous clock's `voutLow` when the phases are enabled on that clock, and is 0 when they are not.
- R11: With `UseDlyCount` = 1, `dlyTrip` is ignored. The block latches off on the `DlyCycles`-th clock edge after the edge that entered the delay state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| enPin | input | 1 | Controller enable; two consecutive low samples clear the block |
| limitHit | input | 1 | Current limit reached |
| dlyTrip | input | 1 | Delay comparator: latch-off threshold crossed |
| pgoodInWin | input | 1 | Output voltage is inside the power-good window |
| voutLow | input | 1 | Output voltage is below the startup level |
| ssDone | input | 1 | Soft-start ramp has finished |
| phaseEn | output | 1 | Phases allowed to switch |
| ssReq | output | 1 | One-clock request to start a soft-start ramp |
| latchedOff | output | 1 | Controller is latched off by overcurrent |
| secLimSel | output | 1 | Startup clamp on the error-amplifier command selected |

## Verification
Every output is a register, so each result is due exactly one clock after the edge that samples the stimulus. In the counter variant, the latch follows a fixed `DlyCycles` edges after the delay state is entered. The bench applies inputs two nanoseconds after a rising edge and reads the outputs two nanoseconds after the next rising edge. It then compares each output with the value the requirements give for that single step. The counter variant is checked edge by edge: the latch must be absent on the edges before the expected one and present on that one.

// File: rtl/ocpSeqPkg.sv
package ocpSeqPkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SOFTSTART,
    ST_RUN,
    ST_OC_DELAY,
    ST_LATCHED
  } seqState_t;

  // Strobes from the control FSM to the datapath, all for the coming edge.
  typedef struct packed {
    logic phaseOnNext;  // next state switches the phases
    logic ssPulse;      // next state is a fresh entry into soft-start
    logic latchNext;    // next state is latched off
    logic inDelay;      // current state is the overcurrent delay
  } seqStrobe_t;

endpackage

// File: rtl/ocp_seq_ctrl.sv
module ocp_seq_ctrl
  import ocpSeqPkg::*;
(
  input  logic       clk,
  input  logic       porRstN,
  input  logic       enPin,
  input  logic       limitHit,
  input  logic       pgoodInWin,
  input  logic       ssDone,
  input  logic       enOffReq,
  input  logic       tripNow,
  output seqStrobe_t strobe
);

  seqState_t state;
  seqState_t nxt;

  always_comb begin
    nxt = state;
    if (enOffReq) begin
      nxt = ST_OFF;
    end else begin
      case (state)
        ST_OFF:       if (enPin) nxt = ST_SOFTSTART;
        ST_SOFTSTART: begin
          if (limitHit)    nxt = ST_OC_DELAY;
          else if (ssDone) nxt = ST_RUN;
        end
        ST_RUN:       if (limitHit) nxt = ST_OC_DELAY;
        ST_OC_DELAY: begin
          // Threshold has priority over a fault that clears in the same clock.
          if (tripNow)        nxt = ST_LATCHED;
          else if (!limitHit) nxt = pgoodInWin ? ST_RUN : ST_SOFTSTART;
        end
        ST_LATCHED:   nxt = ST_LATCHED;
        default:      nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) state <= ST_OFF;
    else          state <= nxt;
  end

  always_comb begin
    strobe.phaseOnNext = (nxt == ST_SOFTSTART) || (nxt == ST_RUN) || (nxt == ST_OC_DELAY);
    strobe.ssPulse     = (nxt == ST_SOFTSTART) && (state != ST_SOFTSTART);
    strobe.latchNext   = (nxt == ST_LATCHED);
    strobe.inDelay     = (state == ST_OC_DELAY);
  end

endmodule

// File: rtl/ocp_seq_dp.sv
module ocp_seq_dp
  import ocpSeqPkg::*;
#(
  parameter int EnLowClocks = 2,
  parameter bit UseDlyCount = 1'b0,
  parameter int DlyCycles   = 4
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       enPin,
  input  logic       dlyTrip,
  input  logic       voutLow,
  input  seqStrobe_t strobe,
  output logic       enOffReq,
  output logic       tripNow,
  output logic       phaseEn,
  output logic       ssReq,
  output logic       latchedOff,
  output logic       secLimSel
);

  localparam int EW = (EnLowClocks > 2) ? $clog2(EnLowClocks) : 1;
  localparam logic [EW-1:0] EN_TOP = EW'(EnLowClocks - 1);

  // Enable-low glitch filter: counts earlier consecutive low samples.
  logic [EW-1:0] enLowCnt;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)               enLowCnt <= '0;
    else if (enPin)             enLowCnt <= '0;
    else if (enLowCnt != EN_TOP) enLowCnt <= enLowCnt + 1'b1;
  end

  assign enOffReq = !enPin && (enLowCnt == EN_TOP);

  // Threshold source picked by parameter.
  generate
    if (UseDlyCount) begin : g_dlyCount
      localparam int CW = $clog2(DlyCycles + 1);
      localparam logic [CW-1:0] DLY_TOP = CW'(DlyCycles - 1);
      logic [CW-1:0] dlyCnt;

      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN)           dlyCnt <= '0;
        else if (strobe.inDelay) dlyCnt <= dlyCnt + 1'b1;
        else                    dlyCnt <= '0;
      end

      assign tripNow = strobe.inDelay && (dlyCnt == DLY_TOP);
    end else begin : g_dlyComp
      assign tripNow = strobe.inDelay && dlyTrip;
    end
  endgenerate

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      phaseEn    <= 1'b0;
      ssReq      <= 1'b0;
      latchedOff <= 1'b0;
      secLimSel  <= 1'b0;
    end else begin
      phaseEn    <= strobe.phaseOnNext;
      ssReq      <= strobe.ssPulse;
      latchedOff <= strobe.latchNext;
      secLimSel  <= strobe.phaseOnNext && voutLow;
    end
  end

endmodule

// File: rtl/ocp_fault_seq.sv
module ocp_fault_seq
  import ocpSeqPkg::*;
#(
  parameter int EnLowClocks = 2,
  parameter bit UseDlyCount = 1'b0,
  parameter int DlyCycles   = 4
) (
  input  logic clk,
  input  logic porRstN,
  input  logic enPin,
  input  logic limitHit,
  input  logic dlyTrip,
  input  logic pgoodInWin,
  input  logic voutLow,
  input  logic ssDone,
  output logic phaseEn,
  output logic ssReq,
  output logic latchedOff,
  output logic secLimSel
);

  seqStrobe_t strobe;
  logic       enOffReq;
  logic       tripNow;

  ocp_seq_ctrl ctrl_i (
    .clk        (clk),
    .porRstN    (porRstN),
    .enPin      (enPin),
    .limitHit   (limitHit),
    .pgoodInWin (pgoodInWin),
    .ssDone     (ssDone),
    .enOffReq   (enOffReq),
    .tripNow    (tripNow),
    .strobe     (strobe)
  );

  ocp_seq_dp #(
    .EnLowClocks (EnLowClocks),
    .UseDlyCount (UseDlyCount),
    .DlyCycles   (DlyCycles)
  ) dp_i (
    .clk        (clk),
    .porRstN    (porRstN),
    .enPin      (enPin),
    .dlyTrip    (dlyTrip),
    .voutLow    (voutLow),
    .strobe     (strobe),
    .enOffReq   (enOffReq),
    .tripNow    (tripNow),
    .phaseEn    (phaseEn),
    .ssReq      (ssReq),
    .latchedOff (latchedOff),
    .secLimSel  (secLimSel)
  );

endmodule

// File: rtl/ocp_fault_seq_chk.sv
module ocp_fault_seq_chk #(
  parameter bit UseDlyCount = 1'b0
) (
  input logic clk,
  input logic porRstN,
  input logic enPin,
  input logic dlyTrip,
  input logic phaseEn,
  input logic ssReq,
  input logic latchedOff,
  input logic secLimSel
);

  // R2: soft-start request lasts a single clock
  p_ss_single_r2: assert property (@(posedge clk) disable iff (!porRstN)
    ssReq |=> !ssReq);

  // R6: a soft-start request always comes with the phases switching
  p_ss_with_phase_r6: assert property (@(posedge clk) disable iff (!porRstN)
    ssReq |-> phaseEn);

  // R4: latched off means the phases are stopped
  p_latch_no_phase_r4: assert property (@(posedge clk) disable iff (!porRstN)
    latchedOff |-> !phaseEn);

  // R4: with the comparator source, a latch follows a sampled threshold
  p_latch_cause_r4: assert property (@(posedge clk) disable iff (!porRstN)
    (!UseDlyCount && $rose(latchedOff)) |-> $past(dlyTrip));

  // R7: a high enable sample never releases the latch
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!porRstN)
    (latchedOff && enPin) |=> latchedOff);

  // R10: the startup clamp is only selected while phases switch
  p_sec_needs_phase_r10: assert property (@(posedge clk) disable iff (!porRstN)
    secLimSel |-> phaseEn);

endmodule

bind ocp_fault_seq ocp_fault_seq_chk #(.UseDlyCount(UseDlyCount)) chk_i (
  .clk        (clk),
  .porRstN    (porRstN),
  .enPin      (enPin),
  .dlyTrip    (dlyTrip),
  .phaseEn    (phaseEn),
  .ssReq      (ssReq),
  .latchedOff (latchedOff),
  .secLimSel  (secLimSel)
);

// File: tb/ocp_fault_seq_tb.sv
`timescale 1ns/1ps
module ocp_fault_seq_tb_top;

  localparam int CLK_HALF  = 10;  // 50 MHz
  localparam int DLY_CNT   = 4;
  localparam int NUM_VEC   = 18;

  logic clk = 1'b0;
  logic porRstN;
  logic enPin, limitHit, dlyTrip, pgoodInWin, voutLow, ssDone;
  logic phaseEn, ssReq, latchedOff, secLimSel;
  logic phaseEnC, ssReqC, latchedOffC, secLimSelC;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #CLK_HALF clk = ~clk;

  ocp_fault_seq dut_i (
    .clk(clk), .porRstN(porRstN), .enPin(enPin), .limitHit(limitHit),
    .dlyTrip(dlyTrip), .pgoodInWin(pgoodInWin), .voutLow(voutLow), .ssDone(ssDone),
    .phaseEn(phaseEn), .ssReq(ssReq), .latchedOff(latchedOff), .secLimSel(secLimSel)
  );

  ocp_fault_seq #(.UseDlyCount(1'b1), .DlyCycles(DLY_CNT)) dut_cnt_i (
    .clk(clk), .porRstN(porRstN), .enPin(enPin), .limitHit(limitHit),
    .dlyTrip(dlyTrip), .pgoodInWin(pgoodInWin), .voutLow(voutLow), .ssDone(ssDone),
    .phaseEn(phaseEnC), .ssReq(ssReqC), .latchedOff(latchedOffC), .secLimSel(secLimSelC)
  );

  // Vector: [13:10] requirement, [9:4] en lim trip pg vlow done,
  // [3:0] expected phaseEn ssReq latchedOff secLimSel after one edge.
  localparam logic [13:0] VEC [NUM_VEC] = '{
    {4'd2,  6'b100110, 4'b1101},  // R2 start soft-start
    {4'd2,  6'b100110, 4'b1001},  // R2 pulse is single
    {4'd2,  6'b100101, 4'b1000},  // R2 done -> run
    {4'd3,  6'b110100, 4'b1000},  // R3 enter delay
    {4'd3,  6'b110100, 4'b1000},  // R3 still switching
    {4'd5,  6'b100100, 4'b1000},  // R5 clear, pgood ok -> run
    {4'd3,  6'b110100, 4'b1000},  // R3 delay again
    {4'd6,  6'b100010, 4'b1101},  // R6 clear, pgood low -> soft-start
    {4'd10, 6'b100110, 4'b1001},  // R10 clamp follows voutLow
    {4'd2,  6'b100101, 4'b1000},  // R2 done -> run
    {4'd3,  6'b110100, 4'b1000},  // R3 delay
    {4'd4,  6'b111100, 4'b0010},  // R4 threshold -> latched
    {4'd10, 6'b100110, 4'b0010},  // R10 no clamp while latched
    {4'd7,  6'b000110, 4'b0010},  // R7 single low enable
    {4'd7,  6'b111110, 4'b0010},  // R7 fault inputs ignored
    {4'd8,  6'b000100, 4'b0010},  // R8 first low sample
    {4'd8,  6'b000100, 4'b0000},  // R8 second low -> off
    {4'd8,  6'b100110, 4'b1101}   // R8 restart soft-start
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {phaseEn,ssReq,latchedOff,secLimSel} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic setIn(input logic [5:0] v);
    {enPin, limitHit, dlyTrip, pgoodInWin, voutLow, ssDone} = v;
  endtask

  task automatic doReset();
    porRstN = 1'b0;
    setIn(6'b000100);
    repeat (3) @(posedge clk);
    #2;
    porRstN = 1'b1;
  endtask

  initial begin
    #(2 * CLK_HALF * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs clear in reset and on first clock after
    porRstN = 1'b0;
    setIn(6'b000100);
    #5;
    repeat (2) @(posedge clk);
    #2;
    chk("R1 in reset", {phaseEn, ssReq, latchedOff, secLimSel}, 4'b0000);
    porRstN = 1'b1;
    step();
    chk("R1 after release", {phaseEn, ssReq, latchedOff, secLimSel}, 4'b0000);

    // Table walk
    for (int i = 0; i < NUM_VEC; i++) begin
      setIn(VEC[i][9:4]);
      step();
      chk($sformatf("R%0d vec %0d", VEC[i][13:10], i),
          {phaseEn, ssReq, latchedOff, secLimSel}, VEC[i][3:0]);
    end

    // R9: threshold held low, long overload never latches
    doReset();
    setIn(6'b100100); step();
    setIn(6'b100101); step();
    setIn(6'b110100);
    begin
      logic bad = 1'b0;
      for (int k = 0; k < 60; k++) begin
        step();
        if (!phaseEn || latchedOff) bad = 1'b1;
      end
      chk("R9 no latch", {phaseEn, 1'b0, latchedOff, bad}, 4'b1000);
    end

    // R4: threshold wins over a clear in the same clock
    setIn(6'b101100); step();
    chk("R4 trip priority", {phaseEn, ssReq, latchedOff, secLimSel}, 4'b0010);

    // R8: two low enable samples from run stop the phases
    doReset();
    setIn(6'b100100); step();
    setIn(6'b100101); step();
    setIn(6'b000100); step();
    chk("R8 one low keeps run", {phaseEn, ssReq, latchedOff, secLimSel}, 4'b1000);
    step();
    chk("R8 two lows -> off", {phaseEn, ssReq, latchedOff, secLimSel}, 4'b0000);

    // R11: counter variant latches DlyCycles edges after entering delay
    doReset();
    setIn(6'b100100); step();
    setIn(6'b100101); step();
    setIn(6'b111100);  // dlyTrip high: ignored by the counter variant
    step();            // enters delay
    for (int k = 1; k < DLY_CNT; k++) begin
      step();
      chk($sformatf("R11 edge %0d", k), {phaseEnC, ssReqC, latchedOffC, secLimSelC}, 4'b1000);
    end
    step();
    chk("R11 latch edge", {phaseEnC, ssReqC, latchedOffC, secLimSelC}, 4'b0010);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule